// File: doc/BRIEF.md
# Video Frame Reader Control and Status Registers

This block is the software-facing register file for the output (read) side of a triple-buffered video frame store. A host reaches it through a small 16-bit register bus with an address, a write strobe with write data, and a read strobe with combinational read data. The block holds a run request, reports whether the reader is actually running, keeps two sticky interrupt flags, and counts output frames, splitting them into fresh frames and frames the reader is about to show again.

The reader datapath reports each finished output frame with a one-cycle pulse tagged as fresh or repeated. It also signals status-update and stable-video events. The run request set by software is copied to the datapath's run enable only on a control-update pulse from the datapath, so a stop never cuts a frame short. While the reader is halted, the input side either accepts and discards incoming frames or back-pressures them, depending on a build-time parameter.

Top module: `frd_ctrl`

## Requirements
- R1: After reset the run request, the run enable, both interrupt flags and both counters are zero, `stopped` is 1 and `irq` is 0.
- R2: Writing address 0 stores write-data bit 0 as the run request. A read of address 0 returns the request in bit 0 and zeros in bits 15..1.
- R3: `run_en` takes the run request only on a clock edge where `ctrl_update` is high and otherwise holds. Address 1 reads `run_en` in bit 0 with the other bits zero, and `stopped` is the inverse of `run_en`.
- R4: Address 2 bit 1 is a sticky flag set by `ev_status` and bit 2 is a sticky flag set by `ev_stable`. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged. Bit 0 and bits 15..3 read zero.
- R5: An event arriving in the same cycle as a write that clears its flag leaves the flag set.
- R6: `irq` is high exactly when at least one sticky flag is set.
- R7: Address 3 counts `eof_pulse` cycles with `eof_repeat` low, and address 4 counts `eof_pulse` cycles with `eof_repeat` high. Both counters wrap from 0xFFFF to 0.
- R8: Writes to addresses 3 and 4 do not change the counters.
- R9: Addresses 5 to 7 read zero, and writes to them change no register.
- R10: While running, `in_ready` is 1 and `in_drop` is 0. While stopped with `DROP_EN`=1, `in_ready` is 1 and `in_drop` follows `in_valid`. While stopped with `DROP_EN`=0, `in_ready` is 0 and `in_drop` is 0.
- R11: `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, same cycle as `bus_rd` |
| eof_pulse | input | 1 | End of an output frame |
| eof_repeat | input | 1 | Qualifies `eof_pulse`: the frame is about to be repeated |
| ev_status | input | 1 | Status-update event |
| ev_stable | input | 1 | Stable-video event |
| ctrl_update | input | 1 | Datapath control-update point |
| in_valid | input | 1 | An input frame is offered |
| in_ready | output | 1 | Input side may accept |
| in_drop | output | 1 | Accepted input is discarded |
| run_en | output | 1 | Run enable to the reader datapath |
| stopped | output | 1 | Reader is halted |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets a stop request written between update points. A design that applied the run request at once would drop `run_en` before the next `ctrl_update` pulse. It also drives an event in the same cycle as the write that clears its flag. A design that let the clear win would lose an interrupt. Writes to the counter and unused addresses, and a full wrap of the frame counter, catch counters that take bus data or saturate. Two instances, one per `DROP_EN` setting, show the difference between discarding and back-pressuring input while halted.

// File: rtl/frd_pkg.sv
package frd_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_IRQ    = 3'd2;
  localparam logic [ADDR_W-1:0] A_FRAMES = 3'd3;
  localparam logic [ADDR_W-1:0] A_REPS   = 3'd4;

  // flag bit positions inside the interrupt register
  localparam int unsigned IRQ_STATUS_BIT = 1;
  localparam int unsigned IRQ_STABLE_BIT = 2;
  localparam int unsigned NUM_FLAGS      = 2;

  function automatic logic [REG_W-1:0] count_next(input logic [REG_W-1:0] cur,
                                                   input logic inc);
    return inc ? cur + REG_W'(1) : cur;
  endfunction

  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/frd_run_ctrl.sv
module frd_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic go_wr,
  input  logic go_val,
  input  logic ctrl_update,
  output logic go_q,
  output logic run_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      if (go_wr)       go_q  <= go_val;
      if (ctrl_update) run_q <= go_q;
    end
  end
endmodule

// File: rtl/frd_irq_flags.sv
module frd_irq_flags
  import frd_pkg::*;
#(
  parameter int unsigned N = NUM_FLAGS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_next(flags[i], set[i], clr[i]);
    end
  end
endmodule

// File: rtl/frd_event_counter.sv
module frd_event_counter
  import frd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [REG_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_next(count, inc);
  end
endmodule

// File: rtl/frd_input_gate.sv
module frd_input_gate #(
  parameter bit DROP_EN = 1'b1
) (
  input  logic running,
  input  logic in_valid,
  output logic in_ready,
  output logic in_drop
);
  if (DROP_EN) begin : g_discard
    assign in_ready = 1'b1;
    assign in_drop  = ~running & in_valid;
  end else begin : g_stall
    assign in_ready = running;
    assign in_drop  = 1'b0;
  end
endmodule

// File: rtl/frd_ctrl.sv
module frd_ctrl
  import frd_pkg::*;
#(
  parameter bit DROP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              eof_pulse,
  input  logic              eof_repeat,
  input  logic              ev_status,
  input  logic              ev_stable,
  input  logic              ctrl_update,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              in_drop,
  output logic              run_en,
  output logic              stopped,
  output logic              irq
);
  localparam int unsigned NCNT = 2;

  // named internal events, visible to the bound checker
  logic                 go_bit;
  logic                 run_q;
  logic                 wr_ctrl, wr_irq;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags;
  logic                 inc_frame, inc_repeat;
  logic [REG_W-1:0]     frame_cnt, repeat_cnt;
  logic                 unused_wdata;

  assign wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
  assign wr_irq     = bus_wr && (bus_addr == A_IRQ);
  assign inc_frame  = eof_pulse & ~eof_repeat;
  assign inc_repeat = eof_pulse &  eof_repeat;

  assign flag_set = {ev_stable, ev_status};
  assign flag_clr = {wr_irq & bus_wdata[IRQ_STABLE_BIT],
                     wr_irq & bus_wdata[IRQ_STATUS_BIT]};
  assign unused_wdata = ^bus_wdata[REG_W-1:IRQ_STABLE_BIT+1];

  frd_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .go_wr(wr_ctrl), .go_val(bus_wdata[0]),
    .ctrl_update(ctrl_update), .go_q(go_bit), .run_q(run_q)
  );

  frd_irq_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(flags)
  );

  logic [NCNT-1:0]  cnt_inc;
  logic [REG_W-1:0] cnt_val [NCNT];
  assign cnt_inc = {inc_repeat, inc_frame};

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    frd_event_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[k]), .count(cnt_val[k])
    );
  end
  assign frame_cnt  = cnt_val[0];
  assign repeat_cnt = cnt_val[1];

  frd_input_gate #(.DROP_EN(DROP_EN)) u_gate (
    .running(run_q), .in_valid(in_valid), .in_ready(in_ready), .in_drop(in_drop)
  );

  assign run_en  = run_q;
  assign stopped = ~run_q;
  assign irq     = |flags;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_CTRL:   bus_rdata[0] = go_bit;
        A_STATUS: bus_rdata[0] = run_q;
        A_IRQ: begin
          bus_rdata[IRQ_STATUS_BIT] = flags[0];
          bus_rdata[IRQ_STABLE_BIT] = flags[1];
        end
        A_FRAMES: bus_rdata = frame_cnt;
        A_REPS:   bus_rdata = repeat_cnt;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/frd_ctrl_chk.sv
module frd_ctrl_chk
  import frd_pkg::*;
#(
  parameter bit DROP_EN = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ctrl_update,
  input logic                 go_bit,
  input logic                 run_en,
  input logic                 ev_status,
  input logic                 ev_stable,
  input logic                 wr_irq,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] flag_clr,
  input logic                 irq,
  input logic                 inc_frame,
  input logic                 inc_repeat,
  input logic [REG_W-1:0]     frame_cnt,
  input logic [REG_W-1:0]     repeat_cnt,
  input logic                 stopped,
  input logic                 in_ready
);
  p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_update |=> $stable(run_en));

  p_run_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_update |=> run_en == $past(go_bit));

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flag_clr[0]) |=> flags[0]);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_status && wr_irq) |=> flags[0]);

  p_stable_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stable |=> flags[1]);

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_status || ev_stable));

  p_frame_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc_frame |=> frame_cnt == $past(frame_cnt) + 16'd1);

  p_repeat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inc_repeat |=> repeat_cnt == $past(repeat_cnt) + 16'd1);

  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_frame || inc_repeat) |=> ($stable(frame_cnt) && $stable(repeat_cnt)));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !DROP_EN) |-> !in_ready);
endmodule

bind frd_ctrl frd_ctrl_chk #(.DROP_EN(DROP_EN)) u_chk (.*);

// File: tb/sim_frd_ctrl.sv
module sim_frd_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        eof_pulse = 1'b0, eof_repeat = 1'b0;
  logic        ev_status = 1'b0, ev_stable = 1'b0, ctrl_update = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] rdata0, rdata1;
  logic        rdy0, drp0, run0, stp0, irq0;
  logic        rdy1, drp1, run1, stp1, irq1;

  always #(CLK_PERIOD/2) clk = ~clk;

  frd_ctrl #(.DROP_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata0),
    .eof_pulse(eof_pulse), .eof_repeat(eof_repeat), .ev_status(ev_status),
    .ev_stable(ev_stable), .ctrl_update(ctrl_update), .in_valid(in_valid),
    .in_ready(rdy0), .in_drop(drp0), .run_en(run0), .stopped(stp0), .irq(irq0));

  frd_ctrl #(.DROP_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata1),
    .eof_pulse(eof_pulse), .eof_repeat(eof_repeat), .ev_status(ev_status),
    .ev_stable(ev_stable), .ctrl_update(ctrl_update), .in_valid(in_valid),
    .in_ready(rdy1), .in_drop(drp1), .run_en(run1), .stopped(stp1), .irq(irq1));

  // behavioural reference state
  int m_go, m_run, m_fs, m_fv, m_fcnt, m_rcnt;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_go = 0; m_run = 0; m_fs = 0; m_fv = 0; m_fcnt = 0; m_rcnt = 0;
    end else begin
      if (ctrl_update) m_run = m_go;
      if (bus_wr && bus_addr == 0) m_go = bus_wdata[0];
      if (ev_status) m_fs = 1;
      else if (bus_wr && bus_addr == 2 && bus_wdata[1]) m_fs = 0;
      if (ev_stable) m_fv = 1;
      else if (bus_wr && bus_addr == 2 && bus_wdata[2]) m_fv = 0;
      if (eof_pulse) begin
        if (eof_repeat) m_rcnt = (m_rcnt + 1) % 65536;
        else            m_fcnt = (m_fcnt + 1) % 65536;
      end
    end
  end

  function automatic int exp_rd(input int a);
    if (!bus_rd) return 0;
    case (a)
      0: return m_go;
      1: return m_run;
      2: return m_fs * 2 + m_fv * 4;
      3: return m_fcnt;
      4: return m_rcnt;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input int a);
    if (!bus_rd) return "R11";
    case (a)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3, 4: return "R7"; default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 run_en", int'(run0), m_run);
      chk("R3 stopped", int'(stp0), 1 - m_run);
      chk("R6 irq", int'(irq0), (m_fs | m_fv));
      chk("R10 ready drop-mode", int'(rdy0), 1);
      chk("R10 drop drop-mode", int'(drp0), (m_run == 0 && in_valid) ? 1 : 0);
      chk("R10 ready stall-mode", int'(rdy1), m_run);
      chk("R10 drop stall-mode", int'(drp1), 0);
      chk(rd_tag(int'(bus_addr)), int'(rdata0), exp_rd(int'(bus_addr)));
      chk("R11 second instance rdata", int'(rdata1), int'(rdata0));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 3'(a); bus_wdata = 16'(d); bus_wr = 1'b1; step(); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    bus_addr = 3'(a); bus_rd = 1'b1;
    @(negedge clk); chk(tag, int'(rdata0), exp);
    step(); bus_rd = 1'b0;
  endtask

  task automatic pulse_update();
    ctrl_update = 1'b1; step(); ctrl_update = 1'b0;
  endtask

  task automatic frame(input bit rep);
    eof_pulse = 1'b1; eof_repeat = rep; step(); eof_pulse = 1'b0; eof_repeat = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1; step();
    // R1 reset state
    chk("R1 stopped", int'(stp0), 1);
    chk("R1 irq", int'(irq0), 0);
    for (int a = 0; a < 8; a++) rd(a, 0, "R1 reset register");

    // R2 run request
    wr(0, 16'hFFFF);
    rd(0, 1, "R2 control readback");
    chk("R3 run held before update", int'(run0), 0);
    step();
    chk("R3 run still held", int'(run0), 0);
    pulse_update();
    chk("R3 run after update", int'(run0), 1);
    rd(1, 1, "R3 status running");

    // R10 input while running
    in_valid = 1'b1; step();
    chk("R10 running no drop", int'(drp0), 0);
    in_valid = 1'b0;

    // R4 interrupt flags
    ev_status = 1'b1; step(); ev_status = 1'b0;
    rd(2, 2, "R4 status flag");
    ev_stable = 1'b1; step(); ev_stable = 1'b0;
    rd(2, 6, "R4 both flags");
    wr(2, 0);
    rd(2, 6, "R4 write 0 ignored");
    wr(2, 2);
    rd(2, 4, "R4 clear status only");
    // R5 event with clear in the same cycle
    ev_stable = 1'b1; wr(2, 4); ev_stable = 1'b0;
    rd(2, 4, "R5 set wins over clear");
    chk("R6 irq with flag", int'(irq0), 1);
    wr(2, 16'hFFFF);
    rd(2, 0, "R4 clear all");
    chk("R6 irq cleared", int'(irq0), 0);

    // R7 counting
    for (int i = 0; i < 5; i++) frame(0);
    for (int i = 0; i < 3; i++) frame(1);
    frame(0); frame(1);
    rd(3, 6, "R7 fresh frames");
    rd(4, 4, "R7 repeated frames");

    // R8 counters ignore writes
    wr(3, 16'h1234); wr(4, 16'hABCD);
    rd(3, 6, "R8 frame counter write ignored");
    rd(4, 4, "R8 repeat counter write ignored");

    // R9 unused addresses
    for (int a = 5; a < 8; a++) wr(a, 16'hFFFF);
    for (int a = 5; a < 8; a++) rd(a, 0, "R9 unused reads zero");
    rd(0, 1, "R9 control untouched");
    rd(2, 0, "R9 flags untouched");

    // stop request waits for update (R3), then input gating (R10)
    wr(0, 0);
    step(); step();
    chk("R3 stop deferred", int'(run0), 1);
    pulse_update();
    chk("R3 stopped after update", int'(stp0), 1);
    in_valid = 1'b1; step();
    chk("R10 drop while halted", int'(drp0), 1);
    chk("R10 stall while halted", int'(rdy1), 0);
    in_valid = 1'b0; step();

    // R11 no read strobe
    bus_addr = 3'd3; step();
    chk("R11 idle rdata", int'(rdata0), 0);

    // R7 wrap
    eof_pulse = 1'b1;
    while (m_fcnt != 65535) step();
    eof_pulse = 1'b0; step();
    rd(3, 16'hFFFF, "R7 at top");
    frame(0);
    rd(3, 0, "R7 wrap to zero");

    step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule